// File: doc/BRIEF.md
# Status-Decoded Bus Command Controller

This block sits beside a processor that reports each bus cycle through a three-bit active-low status code, and turns that code into the strobes a system bus needs. A cycle begins when the status leaves its passive value. The block then pulses an address latch enable for one clock, captures the code, and drives the matching command strobe, data transceiver enable and transceiver direction until the status goes passive again. Write codes drive two strobes: an advanced one that goes low early, for slow devices, and a normal one that follows a clock later.

Two inputs let a second bus master such as a DMA engine take the bus. An active-low address-enable input must be held low for a set number of clocks before any command may drive, and raising it takes the commands off the bus within one clock. An active-high command-enable input masks the command strobes and the data enable at once. The block always runs in system-bus mode.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: After reset, every command strobe is high, `ale` and `den` are low, `dt_r` is high and `cmd_oe` is low.
- R2: When `status_n` is sampled away from 3'b111 with no cycle in progress, `ale` is high for exactly the next clock and the code is captured; any later change of `status_n` to another non-passive code does not alter the cycle.
- R3: Read-type codes assert one strobe from the clock after `ale` onward: 3'b000 drives `inta_n`, 3'b001 drives `io_rd_n`, 3'b100 and 3'b101 drive `mem_rd_n`.
- R4: Code 3'b010 drives `io_wr_adv_n` from the clock after `ale` and `io_wr_n` one clock later; code 3'b110 does the same with `mem_wr_adv_n` and `mem_wr_n`.
- R5: Code 3'b011 (halt) produces the `ale` pulse but no command strobe and no `den`.
- R6: All strobes and `den` are inactive in the clock after `status_n` is sampled at 3'b111, whatever phase the cycle had reached.
- R7: `dt_r` is low from the `ale` clock to the end of a cycle with a read-type code (3'b000, 3'b001, 3'b100, 3'b101) and high at all other times.
- R8: `den` is high from the clock after `ale` to the end of any non-halt cycle while `cmd_en` is high.
- R9: While `cmd_en` is low, every command strobe is high and `den` is low, with no clock of delay.
- R10: `cmd_oe` goes high, and strobes may go low, only after `addr_en_n` has been sampled low on `AEN_DELAY` consecutive clock edges.
- R11: An edge that samples `addr_en_n` high makes `cmd_oe` low and every strobe high from that edge on.
- R12: At most one of `inta_n`, `io_rd_n`, `mem_rd_n`, `io_wr_adv_n`, `mem_wr_adv_n` is low at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_n | input | 3 | Processor status code, 3'b111 is passive |
| addr_en_n | input | 1 | Active-low address enable; high hands the bus to another master |
| cmd_en | input | 1 | Active-high command enable |
| ale | output | 1 | Address latch enable, one-clock pulse per cycle |
| den | output | 1 | Active-high data transceiver enable |
| dt_r | output | 1 | Transceiver direction, high for write, low for read |
| cmd_oe | output | 1 | Drive enable for the command strobes |
| inta_n | output | 1 | Interrupt acknowledge strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| io_wr_adv_n | output | 1 | Advanced I/O write strobe |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| mem_wr_adv_n | output | 1 | Advanced memory write strobe |

## Verification
A wrong cycle phase shows in the very next clock as an `ale` pulse of the wrong length, a strobe that starts a clock early or late, or a normal write that does not trail its advanced twin. A wrongly captured code shows as the wrong strobe or `dt_r` level from the `ale` clock on, and a grant counter that is off by one shows as `cmd_oe` rising one clock early or late after `addr_en_n` falls. The bench model tracks phase, captured code and grant count on its own and compares every output on every clock, so each of these faults is caught in the clock where it first appears.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;

  localparam int unsigned STATUS_W = 3;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_EARLY = 2'd2,
    PH_LATE  = 2'd3
  } phase_e;

  typedef enum logic [STATUS_W-1:0] {
    ST_INTA    = 3'b000,
    ST_IO_RD   = 3'b001,
    ST_IO_WR   = 3'b010,
    ST_HALT    = 3'b011,
    ST_FETCH   = 3'b100,
    ST_MEM_RD  = 3'b101,
    ST_MEM_WR  = 3'b110,
    ST_PASSIVE = 3'b111
  } status_e;

  function automatic logic is_read_type(input status_e c);
    return (c == ST_INTA) || (c == ST_IO_RD) || (c == ST_FETCH) || (c == ST_MEM_RD);
  endfunction

endpackage

// File: rtl/bcc_rst_sync.sv
module bcc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shreg[LAST];
endmodule

// File: rtl/bcc_phase_seq.sv
module bcc_phase_seq
  import bus_cmd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STATUS_W-1:0] status_n,
  output phase_e              phase,
  output status_e             code
);
  phase_e  phase_nxt;
  logic    passive;
  logic    load_code;

  assign passive   = (status_n == ST_PASSIVE);
  assign load_code = (phase == PH_IDLE) && !passive;

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE:  phase_nxt = passive ? PH_IDLE : PH_ADDR;
      PH_ADDR:  phase_nxt = passive ? PH_IDLE : PH_EARLY;
      PH_EARLY: phase_nxt = passive ? PH_IDLE : PH_LATE;
      PH_LATE:  phase_nxt = passive ? PH_IDLE : PH_LATE;
      default:  phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      code  <= ST_PASSIVE;
    end else begin
      phase <= phase_nxt;
      if (load_code) code <= status_e'(status_n);
    end
  end
endmodule

// File: rtl/bcc_grant_timer.sv
module bcc_grant_timer #(
  parameter int unsigned AEN_DELAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_en_n,
  output logic granted
);
  localparam int unsigned CNT_W = $clog2(AEN_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(AEN_DELAY);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_upd;

  always_comb begin
    cnt_upd = addr_en_n || (cnt != CNT_MAX);
    cnt_nxt = addr_en_n ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (cnt_upd) cnt <= cnt_nxt;
  end

  assign granted = (cnt == CNT_MAX);
endmodule

// File: rtl/bcc_strobe_gen.sv
module bcc_strobe_gen
  import bus_cmd_pkg::*;
(
  input  phase_e  phase,
  input  status_e code,
  input  logic    granted,
  input  logic    cmd_en,
  output logic    ale,
  output logic    den,
  output logic    dt_r,
  output logic    inta_n,
  output logic    io_rd_n,
  output logic    io_wr_n,
  output logic    io_wr_adv_n,
  output logic    mem_rd_n,
  output logic    mem_wr_n,
  output logic    mem_wr_adv_n
);
  logic in_cycle, cmd_phase, late_phase, drive;

  always_comb begin
    in_cycle   = (phase != PH_IDLE);
    cmd_phase  = (phase == PH_EARLY) || (phase == PH_LATE);
    late_phase = (phase == PH_LATE);
    drive      = granted && cmd_en && cmd_phase;

    ale  = (phase == PH_ADDR);
    den  = cmd_en && cmd_phase && (code != ST_HALT);
    dt_r = !(in_cycle && is_read_type(code));

    inta_n       = !(drive && (code == ST_INTA));
    io_rd_n      = !(drive && (code == ST_IO_RD));
    mem_rd_n     = !(drive && ((code == ST_FETCH) || (code == ST_MEM_RD)));
    io_wr_adv_n  = !(drive && (code == ST_IO_WR));
    mem_wr_adv_n = !(drive && (code == ST_MEM_WR));
    io_wr_n      = !(drive && late_phase && (code == ST_IO_WR));
    mem_wr_n     = !(drive && late_phase && (code == ST_MEM_WR));
  end
endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
  import bus_cmd_pkg::*;
#(
  parameter int unsigned AEN_DELAY   = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STATUS_W-1:0] status_n,
  input  logic                addr_en_n,
  input  logic                cmd_en,
  output logic                ale,
  output logic                den,
  output logic                dt_r,
  output logic                cmd_oe,
  output logic                inta_n,
  output logic                io_rd_n,
  output logic                io_wr_n,
  output logic                io_wr_adv_n,
  output logic                mem_rd_n,
  output logic                mem_wr_n,
  output logic                mem_wr_adv_n
);
  logic    rst_core_n;
  phase_e  phase;
  status_e code;
  logic    granted;

  bcc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  bcc_phase_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .status_n (status_n),
    .phase    (phase),
    .code     (code)
  );

  bcc_grant_timer #(.AEN_DELAY(AEN_DELAY)) u_grant (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .addr_en_n (addr_en_n),
    .granted   (granted)
  );

  bcc_strobe_gen u_strb (
    .phase        (phase),
    .code         (code),
    .granted      (granted),
    .cmd_en       (cmd_en),
    .ale          (ale),
    .den          (den),
    .dt_r         (dt_r),
    .inta_n       (inta_n),
    .io_rd_n      (io_rd_n),
    .io_wr_n      (io_wr_n),
    .io_wr_adv_n  (io_wr_adv_n),
    .mem_rd_n     (mem_rd_n),
    .mem_wr_n     (mem_wr_n),
    .mem_wr_adv_n (mem_wr_adv_n)
  );

  assign cmd_oe = granted;
endmodule

// File: rtl/bus_cmd_ctrl_chk.sv
module bus_cmd_ctrl_chk #(
  parameter int unsigned AEN_DELAY = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] status_n,
  input logic       addr_en_n,
  input logic       cmd_en,
  input logic       ale,
  input logic       den,
  input logic       dt_r,
  input logic       cmd_oe,
  input logic       inta_n,
  input logic       io_rd_n,
  input logic       io_wr_n,
  input logic       io_wr_adv_n,
  input logic       mem_rd_n,
  input logic       mem_wr_n,
  input logic       mem_wr_adv_n
);
  int unsigned low_run;
  logic all_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  low_run <= 0;
    else if (addr_en_n)          low_run <= 0;
    else if (low_run < AEN_DELAY) low_run <= low_run + 1;
  end

  assign all_idle = inta_n && io_rd_n && io_wr_n && io_wr_adv_n &&
                    mem_rd_n && mem_wr_n && mem_wr_adv_n;

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2

  AST_IO_WR_TRAILS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(io_wr_n) && $past(cmd_en) && $past(cmd_oe)) |-> $past(!io_wr_adv_n)); // R4

  AST_MEM_WR_TRAILS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_wr_n) && $past(cmd_en) && $past(cmd_oe)) |-> $past(!mem_wr_adv_n)); // R4

  AST_PASSIVE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_n == 3'b111) |=> (all_idle && !den)); // R6

  AST_RD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd_n || !mem_rd_n || !inta_n) |-> !dt_r); // R7

  AST_WR_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr_adv_n || !mem_wr_adv_n) |-> dt_r); // R7

  AST_CMD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_en |-> (all_idle && !den)); // R9

  AST_GRANT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> (low_run >= AEN_DELAY)); // R10

  AST_AEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en_n |=> (!cmd_oe && all_idle)); // R11

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~inta_n, ~io_rd_n, ~mem_rd_n, ~io_wr_adv_n, ~mem_wr_adv_n})); // R12
endmodule

bind bus_cmd_ctrl bus_cmd_ctrl_chk #(.AEN_DELAY(AEN_DELAY)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .status_n     (status_n),
  .addr_en_n    (addr_en_n),
  .cmd_en       (cmd_en),
  .ale          (ale),
  .den          (den),
  .dt_r         (dt_r),
  .cmd_oe       (cmd_oe),
  .inta_n       (inta_n),
  .io_rd_n      (io_rd_n),
  .io_wr_n      (io_wr_n),
  .io_wr_adv_n  (io_wr_adv_n),
  .mem_rd_n     (mem_rd_n),
  .mem_wr_n     (mem_wr_n),
  .mem_wr_adv_n (mem_wr_adv_n)
);

// File: tb/test_bus_cmd_ctrl.sv
`timescale 1ns/1ps
module test_bus_cmd_ctrl;
  localparam int DLY = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] status_n;
  logic       addr_en_n;
  logic       cmd_en;
  logic ale, den, dt_r, cmd_oe, inta_n, io_rd_n, io_wr_n, io_wr_adv_n;
  logic mem_rd_n, mem_wr_n, mem_wr_adv_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit run_cmp = 1'b0;
  string scen = "R1 reset";

  // behavioural reference state
  int m_phase = 0;
  int m_code  = 7;
  int m_gcnt  = 0;

  always #5 clk = ~clk;

  bus_cmd_ctrl #(.AEN_DELAY(DLY)) i_bus_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .status_n(status_n), .addr_en_n(addr_en_n),
    .cmd_en(cmd_en), .ale(ale), .den(den), .dt_r(dt_r), .cmd_oe(cmd_oe),
    .inta_n(inta_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .io_wr_adv_n(io_wr_adv_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_wr_adv_n(mem_wr_adv_n)
  );

  task automatic cmp(input string tag, input string name, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s: actual %b expected %b at %0t", tag, scen, name, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_code = 7; m_gcnt = 0;
    end else begin
      if (!addr_en_n) m_gcnt = (m_gcnt < DLY) ? m_gcnt + 1 : DLY;
      else            m_gcnt = 0;
      case (m_phase)
        0: if (status_n != 3'b111) begin m_phase = 1; m_code = int'(status_n); end
        1: m_phase = (status_n == 3'b111) ? 0 : 2;
        default: m_phase = (status_n == 3'b111) ? 0 : 3;
      endcase
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      bit g, act, late, rdt;
      int low_cnt;
      g    = (m_gcnt == DLY) && cmd_en;
      act  = (m_phase >= 2);
      late = (m_phase == 3);
      rdt  = (m_code == 0) || (m_code == 1) || (m_code == 4) || (m_code == 5);
      cmp("R2",  "ale",          ale,          m_phase == 1);
      cmp("R3",  "inta_n",       inta_n,       !(g && act && m_code == 0));
      cmp("R3",  "io_rd_n",      io_rd_n,      !(g && act && m_code == 1));
      cmp("R3",  "mem_rd_n",     mem_rd_n,     !(g && act && (m_code == 4 || m_code == 5)));
      cmp("R4",  "io_wr_adv_n",  io_wr_adv_n,  !(g && act && m_code == 2));
      cmp("R4",  "io_wr_n",      io_wr_n,      !(g && late && m_code == 2));
      cmp("R4",  "mem_wr_adv_n", mem_wr_adv_n, !(g && act && m_code == 6));
      cmp("R4",  "mem_wr_n",     mem_wr_n,     !(g && late && m_code == 6));
      cmp("R7",  "dt_r",         dt_r,         !(m_phase >= 1 && rdt));
      cmp("R8",  "den",          den,          cmd_en && act && m_code != 3);
      cmp("R10", "cmd_oe",       cmd_oe,       m_gcnt == DLY);
      low_cnt = int'(!inta_n) + int'(!io_rd_n) + int'(!mem_rd_n) +
                int'(!io_wr_adv_n) + int'(!mem_wr_adv_n);
      cmp("R12", "one_strobe",   low_cnt <= 1, 1'b1);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_cycle(input logic [2:0] code, input int hold);
    status_n = code;
    step(hold);
    status_n = 3'b111;
    step(2);
  endtask

  initial begin : wdog
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; status_n = 3'b111; addr_en_n = 1'b1; cmd_en = 1'b1;
    step(3);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    step(4);
    // R1: reset levels seen at ports before any stimulus
    @(negedge clk);
    cmp("R1", "reset_strobes", {inta_n, io_rd_n, io_wr_n, io_wr_adv_n, mem_rd_n, mem_wr_n, mem_wr_adv_n} == 7'h7f, 1'b1);
    cmp("R1", "reset_levels", {ale, den, dt_r, cmd_oe} == 4'b0010, 1'b1);
    step(1);

    scen = "R10 grant wait";
    addr_en_n = 1'b0;
    bus_cycle(3'b101, 6);
    step(2);

    scen = "R3/R4 all codes";
    for (int c = 0; c < 7; c++) bus_cycle(3'(c), 4);

    scen = "R5 halt";
    bus_cycle(3'b011, 5);

    scen = "R6 short cycles";
    bus_cycle(3'b010, 1);
    bus_cycle(3'b110, 2);
    bus_cycle(3'b001, 1);

    scen = "R2 code change ignored";
    status_n = 3'b001; step(2);
    status_n = 3'b110; step(3);
    status_n = 3'b111; step(2);

    scen = "R9 cmd_en mask";
    status_n = 3'b110; step(3);
    cmd_en = 1'b0; step(2);
    cmd_en = 1'b1; step(2);
    status_n = 3'b111; step(2);

    scen = "R11 bus handed away";
    status_n = 3'b000; step(3);
    addr_en_n = 1'b1; step(2);
    addr_en_n = 1'b0; step(5);
    status_n = 3'b111; step(2);

    scen = "R10 brief low pulse";
    addr_en_n = 1'b1; step(1);
    addr_en_n = 1'b0; step(DLY - 1);
    addr_en_n = 1'b1; step(1);
    addr_en_n = 1'b0;
    bus_cycle(3'b100, 6);

    scen = "R4 long writes";
    bus_cycle(3'b010, 8);
    bus_cycle(3'b110, 8);
    step(3);

    run_cmp = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule